// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the register front end of a multi-timer event timer. It owns four shared registers: a read-only capabilities word, a global configuration word with the counter enable, a write-one-to-clear interrupt status word, and a 32-bit main counter. The counter advances on qualified tick enables. Accesses to the per-timer configuration and comparator windows are not stored here. Instead, the block decodes them into one-cycle write strobes. Each strobe carries the lane-merged write data and the byte-lane mask, and is sent to the comparator channel that owns the register.

Requests arrive on a simple valid/ready register port, and ready is always high. Accesses may be 4 or 8 bytes wide. A 64-bit register is seen as two halves, and address bit 2 picks the half for a 4-byte access. When the counter is enabled, or when it is loaded while enabled, the block sends a re-arm pulse so that the comparator channels can recompute their next events. Status bits are set by the interrupt output logic. Software clears them here, and each cleared bit produces a clear pulse back to that logic.

Register map (byte offsets):
- Capabilities: 0x00
- Configuration: 0x08
- Status: 0x10
- Main counter: 0x18
- Timer n configuration: 0x40 + 16·n
- Timer n comparator: 0x48 + 16·n

Top module: `evt_timer_regs`

## Requirements
- R1: An access is honoured only if its size is 4 or 8 bytes and its address is a multiple of that size. Any other write changes no register and raises no strobe or pulse. Any other read returns zero.
- R2: A 4-byte write with address bit 2 set changes only bits 63:32 of the target, using the low 32 bits of the write data. With bit 2 clear, it changes only bits 31:0. A 4-byte read with bit 2 set returns bits 63:32 shifted down. With bit 2 clear, it returns bits 31:0 zero-extended.
- R3: The capabilities word is laid out as follows:
  - bits 7:0 read 1,
  - bits 12:8 read the timer count minus one,
  - bit 13 reads 0 (32-bit counter),
  - bits 15:14 read 0,
  - bits 31:16 read the vendor-identifier parameter,
  - bits 63:32 read the tick period in femtoseconds, the integer part of 10^15 divided by the tick rate (59604644 by default).
- R4: The configuration word stores the bits written to it. Bit 0 is the counter enable. Bit 1 always reads 0.
- R5: While bit 0 of the configuration word is 1, the main counter increments by one on every clock with tick_i high, wrapping modulo 2^32. The counter value is readable at 0x18 and on cnt_o.
- R6: While the enable is 0, the counter holds its value whatever tick_i does. After the enable is set again, counting continues from the held value.
- R7: A counter write merges the data into the zero-extended 64-bit counter value under the lane mask and keeps the low 32 bits. A write to the upper half therefore leaves the counter unchanged. rearm_o pulses for one cycle after two events: a write that takes the enable from 0 to 1, and a counter write while the counter is enabled. It stays low otherwise.
- R8: Status bit n is set by sts_set_i[n]. A status write clears only the bits that are set and written as 1 in the lower half. The cleared bits appear as a one-cycle pulse on sts_clr_o. A set on the same clock as a clear wins.
- R9: A read gives rsp_valid_o high, with its data, exactly one clock after acceptance. Writes produce no response.
- R10: A valid write to the configuration or comparator window of timer n < NUM_TMR pulses bit n of tmr_cfg_wr_o or tmr_cmp_wr_o respectively, for one clock. The pulse comes with the lane-merged data on tmr_wdata_o and the mask on tmr_wmask_o. Timer numbers at or above NUM_TMR give no strobe. Reads of timer windows return zero.
- R11: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter tick enable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, always high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| cnt_o | output | 32 | Main counter value |
| cnt_en_o | output | 1 | Counter enable bit |
| rearm_o | output | 1 | Re-arm pulse to all timers |
| tmr_cfg_wr_o | output | NUM_TMR | Timer configuration write strobes |
| tmr_cmp_wr_o | output | NUM_TMR | Timer comparator write strobes |
| tmr_wdata_o | output | 64 | Lane-merged write data for timers |
| tmr_wmask_o | output | 64 | Lane mask for timers |
| sts_set_i | input | NUM_TMR | Status set from interrupt logic |
| sts_o | output | NUM_TMR | Interrupt status bits |
| sts_clr_o | output | NUM_TMR | Status clear pulses |

## Verification
The bench sweeps every access size from 0 to 8 over every byte offset of the configuration word, and keeps a model of the merged value. A decoder that accepted a misaligned access or picked the wrong half would corrupt that model, or return non-zero data for an access it should drop. The counter is driven through a wrap from 0xFFFFFFFE, through a disable that holds it, and through upper-half writes. A design that leaked ticks while disabled, or that let the upper half reach the count, would read back a different count. The status sweep covers all 256 set patterns against a varied clear pattern, plus a set that lands on the same clock as a clear. The timer sweep writes one slot beyond the timer count, where any strobe at all is a fault.

// File: rtl/etr_pkg.sv
package etr_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP, SEL_CFG, SEL_STS, SEL_CNT, SEL_TCFG, SEL_TCMP
  } sel_e;

  // 8-byte word indices of the shared registers
  localparam int unsigned WRD_CAP = 0;
  localparam int unsigned WRD_CFG = 1;
  localparam int unsigned WRD_STS = 2;
  localparam int unsigned WRD_CNT = 3;
  localparam int unsigned WRD_TMR = 8;   // first timer window word

  localparam int unsigned CFG_EN  = 0;
  localparam int unsigned CFG_LEG = 1;
endpackage

// File: rtl/etr_decode.sv
module etr_decode
  import etr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_TMR = 8,
  parameter int unsigned TIDX_W  = $clog2(NUM_TMR)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic              ok_o,
  output logic              hi_o,
  output sel_e              sel_o,
  output logic [TIDX_W-1:0] tidx_o,
  output logic [63:0]       mask_o,
  output logic [63:0]       data_o
);
  localparam int unsigned WORD_W = ADDR_W - 3;

  logic [WORD_W-1:0] word, toff, tnum;
  logic sz4, sz8;

  always_comb begin
    sz4    = (size_i == 4'd4);
    sz8    = (size_i == 4'd8);
    ok_o   = (sz4 && addr_i[1:0] == 2'b00) || (sz8 && addr_i[2:0] == 3'b000);
    hi_o   = sz4 && addr_i[2];
    word   = addr_i[ADDR_W-1:3];
    toff   = word - WORD_W'(WRD_TMR);
    tnum   = toff >> 1;
    tidx_o = tnum[TIDX_W-1:0];

    if (!ok_o)                                  sel_o = SEL_NONE;
    else if (word == WORD_W'(WRD_CAP))          sel_o = SEL_CAP;
    else if (word == WORD_W'(WRD_CFG))          sel_o = SEL_CFG;
    else if (word == WORD_W'(WRD_STS))          sel_o = SEL_STS;
    else if (word == WORD_W'(WRD_CNT))          sel_o = SEL_CNT;
    else if (word >= WORD_W'(WRD_TMR) && tnum < WORD_W'(NUM_TMR))
      sel_o = toff[0] ? SEL_TCMP : SEL_TCFG;
    else                                        sel_o = SEL_NONE;

    // lane merge: a 4-byte write lands in the half picked by address bit 2
    if (sz8) begin
      mask_o = '1;
      data_o = wdata_i;
    end else if (hi_o) begin
      mask_o = {32'hFFFF_FFFF, 32'h0};
      data_o = {wdata_i[31:0], 32'h0};
    end else begin
      mask_o = {32'h0, 32'hFFFF_FFFF};
      data_o = {32'h0, wdata_i[31:0]};
    end
  end
endmodule

// File: rtl/etr_counter.sv
module etr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (ld_i)           cnt_q <= ld_val_i;
    else if (en_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_tick_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !ld_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_i) |=> $stable(cnt_o));
endmodule

// File: rtl/etr_status.sv
module etr_status #(
  parameter int unsigned NUM_TMR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] set_i,
  input  logic [NUM_TMR-1:0] clr_req_i,
  output logic [NUM_TMR-1:0] sts_o,
  output logic [NUM_TMR-1:0] clr_o
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_o[i] <= 1'b0;
        clr_o[i] <= 1'b0;
      end else begin
        sts_o[i] <= set_i[i] | (sts_o[i] & ~clr_req_i[i]);  // set wins
        clr_o[i] <= sts_o[i] & clr_req_i[i];
      end
    end
  end

  p_clr_only_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_o & ~$past(sts_o)) == '0));

  p_set_sticks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import etr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_TMR   = 8,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter int unsigned TICK_HZ   = 16777216
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [3:0]         req_size_i,
  input  logic [63:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [63:0]        rsp_rdata_o,
  output logic [31:0]        cnt_o,
  output logic               cnt_en_o,
  output logic               rearm_o,
  output logic [NUM_TMR-1:0] tmr_cfg_wr_o,
  output logic [NUM_TMR-1:0] tmr_cmp_wr_o,
  output logic [63:0]        tmr_wdata_o,
  output logic [63:0]        tmr_wmask_o,
  input  logic [NUM_TMR-1:0] sts_set_i,
  output logic [NUM_TMR-1:0] sts_o,
  output logic [NUM_TMR-1:0] sts_clr_o
);
  localparam int unsigned TIDX_W   = $clog2(NUM_TMR);
  localparam logic [63:0] TICK_FS  = 64'd1000000000000000 / 64'(TICK_HZ);
  localparam logic [63:0] CAP_WORD = {TICK_FS[31:0], VENDOR_ID, 3'b000,
                                      5'(NUM_TMR - 1), 8'h01};

  logic              acc_ok, acc_hi;
  sel_e              acc_sel;
  logic [TIDX_W-1:0] acc_tidx;
  logic [63:0]       acc_mask, acc_data;

  etr_decode #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR), .TIDX_W(TIDX_W)) u_dec (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .wdata_i(req_wdata_i),
    .ok_o   (acc_ok),
    .hi_o   (acc_hi),
    .sel_o  (acc_sel),
    .tidx_o (acc_tidx),
    .mask_o (acc_mask),
    .data_o (acc_data)
  );

  logic        wr_go, rd_go, cfg_wr, cnt_ld, en_rise;
  logic [63:0] cfg_q, cfg_nxt, rd_word, rd_val;
  logic [31:0] cnt_ld_val;
  logic [NUM_TMR-1:0] clr_req;

  assign req_ready_o = 1'b1;

  always_comb begin
    wr_go      = req_valid_i && req_write_i && acc_ok;
    rd_go      = req_valid_i && !req_write_i;
    cfg_wr     = wr_go && (acc_sel == SEL_CFG);
    cnt_ld     = wr_go && (acc_sel == SEL_CNT);
    cfg_nxt    = ((cfg_q & ~acc_mask) | (acc_data & acc_mask)) & ~(64'd1 << CFG_LEG);
    en_rise    = cfg_wr && cfg_nxt[CFG_EN] && !cfg_q[CFG_EN];
    // counter is zero-extended to 64 bits, so only the low lane can reach it
    cnt_ld_val = (cnt_o & ~acc_mask[31:0]) | (acc_data[31:0] & acc_mask[31:0]);
    clr_req    = (wr_go && acc_sel == SEL_STS)
               ? (acc_data[NUM_TMR-1:0] & acc_mask[NUM_TMR-1:0]) : '0;

    case (acc_sel)
      SEL_CAP: rd_word = CAP_WORD;
      SEL_CFG: rd_word = cfg_q;
      SEL_STS: rd_word = 64'(sts_o);
      SEL_CNT: rd_word = 64'(cnt_o);
      default: rd_word = '0;
    endcase
    if (req_size_i == 4'd4) rd_val = acc_hi ? {32'h0, rd_word[63:32]} : {32'h0, rd_word[31:0]};
    else                    rd_val = rd_word;
  end

  etr_counter #(.CNT_W(32)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_q[CFG_EN]),
    .tick_i  (tick_i),
    .ld_i    (cnt_ld),
    .ld_val_i(cnt_ld_val),
    .cnt_o   (cnt_o)
  );

  etr_status #(.NUM_TMR(NUM_TMR)) u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (sts_set_i),
    .clr_req_i(clr_req),
    .sts_o    (sts_o),
    .clr_o    (sts_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q        <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      rearm_o      <= 1'b0;
      tmr_cfg_wr_o <= '0;
      tmr_cmp_wr_o <= '0;
      tmr_wdata_o  <= '0;
      tmr_wmask_o  <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_nxt;
      rsp_valid_o  <= rd_go;
      if (rd_go) rsp_rdata_o <= rd_val;
      rearm_o      <= en_rise || (cnt_ld && cfg_q[CFG_EN]);
      tmr_cfg_wr_o <= (wr_go && acc_sel == SEL_TCFG) ? (NUM_TMR'(1) << acc_tidx) : '0;
      tmr_cmp_wr_o <= (wr_go && acc_sel == SEL_TCMP) ? (NUM_TMR'(1) << acc_tidx) : '0;
      if (wr_go) begin
        tmr_wdata_o <= acc_data;
        tmr_wmask_o <= acc_mask;
      end
    end
  end

  assign cnt_en_o = cfg_q[CFG_EN];

  p_bad_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !acc_ok) |=>
      (tmr_cfg_wr_o == '0 && tmr_cmp_wr_o == '0 && !rearm_o && sts_clr_o == '0));

  p_bad_read_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !acc_ok) |=> (rsp_rdata_o == '0));

  p_rearm_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |-> cnt_en_o);

  p_rsp_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i));

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_cfg_wr_o, tmr_cmp_wr_o}));
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 8;
  localparam int AW         = 10;
  localparam int WD_LIMIT   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    size = '0;
  logic [63:0]   wdata = '0;
  logic [NT-1:0] sts_set = '0;
  logic          ready, rsp_valid, cnt_en, rearm;
  logic [63:0]   rdata, twd, twm;
  logic [31:0]   cnt;
  logic [NT-1:0] cfg_wr, cmp_wr, sts, sts_clr;

  evt_timer_regs #(.ADDR_W(AW), .NUM_TMR(NT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(write),
    .req_addr_i(addr), .req_size_i(size), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .cnt_o(cnt), .cnt_en_o(cnt_en), .rearm_o(rearm),
    .tmr_cfg_wr_o(cfg_wr), .tmr_cmp_wr_o(cmp_wr),
    .tmr_wdata_o(twd), .tmr_wmask_o(twm),
    .sts_set_i(sts_set), .sts_o(sts), .sts_clr_o(sts_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic          l_rv, l_rearm;
  logic [63:0]   l_rd, l_wd, l_wm;
  logic [NT-1:0] l_cfgwr, l_cmpwr, l_clr;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [AW-1:0] a, input logic [3:0] sz,
                     input logic [63:0] d, input logic [NT-1:0] setv);
    @(negedge clk);
    valid = 1'b1; write = w; addr = a; size = sz; wdata = d; sts_set = setv;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; sts_set = '0;
    l_rv = rsp_valid; l_rd = rdata; l_rearm = rearm;
    l_cfgwr = cfg_wr; l_cmpwr = cmp_wr; l_clr = sts_clr; l_wd = twd; l_wm = twm;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] sz, input logic [63:0] d);
    bus(1'b1, a, sz, d, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [3:0] sz);
    bus(1'b0, a, sz, '0, '0);
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_set(input logic [NT-1:0] v);
    @(negedge clk); sts_set = v;
    @(negedge clk); sts_set = '0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam logic [63:0] CAP_EXP = (64'd59604644 << 32) | (64'hA5C3 << 16) | (64'd7 << 8) | 64'd1;

  initial begin
    logic [63:0] cfg_m, m, dd, d, exp_cnt;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R5 reset cnt", 64'(cnt), 0);
    chk("R4 reset enable", 64'(cnt_en), 0);
    chk("R8 reset status", 64'(sts), 0);
    chk("R9 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R9 ready", 64'(ready), 1);

    // capabilities
    rd(10'h00, 4'd8); chk("R3 cap 8-byte", l_rd, CAP_EXP);
    chk("R9 read response valid", 64'(l_rv), 1);
    @(negedge clk); chk("R9 response one cycle", 64'(rsp_valid), 0);
    rd(10'h00, 4'd4); chk("R3 R2 cap low half", l_rd, {32'h0, CAP_EXP[31:0]});
    rd(10'h04, 4'd4); chk("R3 R2 cap high half", l_rd, {32'h0, CAP_EXP[63:32]});
    wr(10'h00, 4'd8, '1); chk("R9 write no response", 64'(l_rv), 0);
    rd(10'h00, 4'd8); chk("R3 cap read-only", l_rd, CAP_EXP);

    // size / alignment sweep over the configuration word
    cfg_m = '0;
    for (int sz = 0; sz <= 8; sz++) begin
      for (int off = 0; off < 8; off++) begin
        d  = 64'h0123_4567_89AB_CDEF + 64'(sz * 8 + off) * 64'h0101_0101_0101_0101;
        d[0] = 1'b0;
        ok = (sz == 4 && (off % 4) == 0) || (sz == 8 && off == 0);
        if (ok) begin
          if (sz == 8)       begin m = '1;                         dd = d; end
          else if (off == 4) begin m = {32'hFFFF_FFFF, 32'h0};     dd = {d[31:0], 32'h0}; end
          else               begin m = {32'h0, 32'hFFFF_FFFF};     dd = {32'h0, d[31:0]}; end
          cfg_m = ((cfg_m & ~m) | (dd & m)) & ~64'h2;
        end
        wr(10'(8 + off), 4'(sz), d);
        rd(10'h08, 4'd8); chk("R1 R4 cfg after sized write", l_rd, cfg_m);
        rd(10'(8 + off), 4'(sz));
        if (!ok)           chk("R1 dropped read is zero", l_rd, 0);
        else if (sz == 8)  chk("R4 cfg 8-byte read", l_rd, cfg_m);
        else if (off == 4) chk("R2 cfg high half read", l_rd, {32'h0, cfg_m[63:32]});
        else               chk("R2 cfg low half read", l_rd, {32'h0, cfg_m[31:0]});
      end
    end
    wr(10'h08, 4'd8, 64'h2); rd(10'h08, 4'd8); chk("R4 legacy bit reads zero", l_rd, 0);
    chk("R4 enable still off", 64'(cnt_en), 0);

    // counter load, freeze, wrap, resume
    wr(10'h18, 4'd8, 64'hDEAD_BEEF_1234_5678); chk("R7 no rearm while disabled", 64'(l_rearm), 0);
    rd(10'h18, 4'd8); chk("R7 8-byte load keeps low 32", l_rd, 64'h1234_5678);
    wr(10'h1C, 4'd4, 64'hAAAA); rd(10'h18, 4'd8); chk("R7 upper-half write no effect", l_rd, 64'h1234_5678);
    rd(10'h1C, 4'd4); chk("R2 R7 counter upper half reads zero", l_rd, 0);
    run_ticks(5); chk("R6 disabled counter holds", 64'(cnt), 64'h1234_5678);
    wr(10'h18, 4'd4, 64'hFFFF_FFFE); chk("R7 low-half load", 64'(cnt), 64'hFFFF_FFFE);
    wr(10'h08, 4'd8, 64'h1); chk("R7 rearm on enable rise", 64'(l_rearm), 1);
    chk("R4 enable bit out", 64'(cnt_en), 1);
    run_ticks(3); chk("R5 wrap modulo 2^32", 64'(cnt), 1);
    wr(10'h08, 4'd8, 64'h1); chk("R7 no rearm when already enabled", 64'(l_rearm), 0);
    exp_cnt = 1;
    for (int k = 1; k <= 12; k++) begin
      run_ticks(k);
      repeat (k % 3) @(negedge clk);
      exp_cnt = exp_cnt + 64'(k);
      rd(10'h18, 4'd8); chk("R5 tick count", l_rd, exp_cnt);
    end
    wr(10'h08, 4'd8, 64'h0); chk("R7 no rearm on disable", 64'(l_rearm), 0);
    run_ticks(7); rd(10'h18, 4'd8); chk("R6 frozen after disable", l_rd, exp_cnt);
    wr(10'h08, 4'd4, 64'h1); chk("R7 rearm on re-enable", 64'(l_rearm), 1);
    run_ticks(4); rd(10'h18, 4'd4); chk("R6 resume from held value", l_rd, exp_cnt + 4);
    wr(10'h18, 4'd8, 64'd100); chk("R7 rearm on load while enabled", 64'(l_rearm), 1);
    chk("R7 load while enabled", 64'(cnt), 100);
    wr(10'h08, 4'd8, 64'h0);

    // status write-one-to-clear sweep
    for (int s = 0; s < 256; s++) begin
      logic [NT-1:0] wv;
      wv = 8'((s * 37 + 11) & 255);
      pulse_set(8'(s));
      rd(10'h10, 4'd8); chk("R8 status set", l_rd, 64'(s));
      wr(10'h10, 4'd8, 64'(wv));
      chk("R8 clear pulse", 64'(l_clr), 64'(8'(s) & wv));
      chk("R8 status after clear", 64'(sts), 64'(8'(s) & ~wv));
      wr(10'h10, 4'd8, 64'hFF);
    end
    pulse_set(8'h01);
    bus(1'b1, 10'h10, 4'd8, 64'h1, 8'h01);
    chk("R8 set wins over clear", 64'(sts), 1);
    chk("R8 clear pulse on collision", 64'(l_clr), 1);
    pulse_set(8'hF0);
    wr(10'h14, 4'd4, 64'hFF); chk("R8 R2 upper-half write clears nothing", 64'(sts), 64'hF1);
    chk("R8 no pulse for upper half", 64'(l_clr), 0);
    wr(10'h10, 4'd4, 64'h30); chk("R8 low-half clear", 64'(sts), 64'hC1);
    wr(10'h10, 4'd2, 64'hFF); chk("R1 2-byte status write dropped", 64'(sts), 64'hC1);
    wr(10'h10, 4'd8, 64'hFF); chk("R8 clear all", 64'(sts), 0);

    // timer window strobes
    for (int n = 0; n <= NT; n++) begin
      logic [NT-1:0] e;
      logic [63:0] td;
      e  = (n < NT) ? NT'(1) << n : '0;
      td = 64'hC0DE_0000_0000_0000 | 64'(n * 64'h0001_0001);
      wr(10'(64 + 16 * n), 4'd8, td);
      chk("R10 cfg strobe", 64'(l_cfgwr), 64'(e));
      chk("R10 no cmp strobe on cfg write", 64'(l_cmpwr), 0);
      if (n < NT) begin
        chk("R10 cfg data", l_wd, td);
        chk("R10 cfg mask", l_wm, '1);
      end
      wr(10'(64 + 16 * n + 12), 4'd4, td);
      chk("R10 cmp strobe upper half", 64'(l_cmpwr), 64'(e));
      if (n < NT) begin
        chk("R10 R2 cmp data shifted", l_wd, {td[31:0], 32'h0});
        chk("R10 R2 cmp upper mask", l_wm, {32'hFFFF_FFFF, 32'h0});
      end
      wr(10'(64 + 16 * n + 2), 4'd4, td);
      chk("R1 misaligned timer write no strobe", 64'(l_cfgwr | l_cmpwr), 0);
      rd(10'(64 + 16 * n), 4'd8); chk("R10 timer window read zero", l_rd, 0);
    end

    // unmapped reads
    rd(10'h20, 4'd8);  chk("R11 unmapped 0x20", l_rd, 0);
    rd(10'h30, 4'd8);  chk("R11 unmapped 0x30", l_rd, 0);
    rd(10'h38, 4'd4);  chk("R11 unmapped 0x38", l_rd, 0);
    rd(10'h3F8, 4'd8); chk("R11 unmapped top", l_rd, 0);
    rd(10'h00, 4'd3);  chk("R1 odd-size read zero", l_rd, 0);

    summary();
  end
endmodule